// File: doc/BRIEF.md
# Video pixel input capture port

This block sits at the pixel input of a video encoder. It captures pixel data, a 3-bit overlay code, a 2-bit overlay mode and the blank and sync inputs, and presents them as registered full pixels. It runs on the fast pixel clock `clk`. A half-rate phase input `phase` qualifies the sampling edges in the wide formats.

Four input formats are supported. The first is an 8-bit multiplexed YCbCr 4:2:2 stream, which the block reassembles into complete Y/Cb/Cr pixels. The others are 16-bit YCbCr, 16-bit RGB (5-6-5) and 24-bit RGB. In the wide formats a sample is taken only on clock edges where `phase` is low. When the sync direction control selects output, internally timed blank and sync levels are registered onto dedicated outputs, and these outputs update only on edges where `phase` is high.

Output channels are `pix_a`/`pix_b`/`pix_c`. For YCbCr formats they carry Y/Cb/Cr, and for RGB formats they carry R/G/B.

Top module: `vid_in_capture`

## Requirements
- R1: While `rst` is high, every output is driven to 0 on each clock edge.
- R2: With `fmt`=0 (8-bit YCbCr), bytes arrive on `pix_in[7:0]` in the order Cb, Y(even), Cr, Y(odd). The edge that samples the Cr byte emits the even pixel (Y even, Cb, Cr). The next edge emits the odd pixel (Y odd, same Cb, Cr). `pix_valid` is high for exactly those two cycles of each group of four bytes.
- R3: In 8-bit mode every clock edge is a sample, regardless of `phase`. An edge with `blank_in` high emits no pixel and makes the next unblanked byte the Cb position, even when a group was left incomplete.
- R4: In the wide formats (`fmt`=1,2,3), samples are taken only on edges with `phase` low. `pix_valid` is high for one cycle after each such edge with `blank_in` low. An edge with `phase` high clears `pix_valid` and leaves `pix_a`/`pix_b`/`pix_c` unchanged.
- R5: With `fmt`=1 (16-bit YCbCr), Y is `pix_in[15:8]`. `pix_in[7:0]` carries Cb on the first unblanked sample after a blanked sample, and then alternates Cr, Cb, and so on. Each pixel carries its own Y together with the most recently received Cb and Cr.
- R6: With `fmt`=2 (16-bit RGB), R is `pix_in[15:11]`, G is `pix_in[10:5]` and B is `pix_in[4:0]`. Each field is widened to 8 bits by repeating its top bits below it: R = {r, r[4:2]}, G = {g, g[5:4]}, B = {b, b[4:2]}.
- R7: With `fmt`=3 (24-bit RGB), R is `pix_in[23:16]`, G is `pix_in[15:8]` and B is `pix_in[7:0]`.
- R8: The overlay code, overlay mode and `blank_in`/`hsync_in`/`vsync_in` are registered on the same sampling edges as the pixel: every edge in 8-bit mode, and edges with `phase` low in the wide formats. On other edges they hold.
- R9: When `sync_dir` is 1, `blank_drv`/`hsync_drv`/`vsync_drv` load `int_blank`/`int_hsync`/`int_vsync` only on edges with `phase` high. When `sync_dir` is 0 they are 0.
- R10: `fmt` may change only while `blank_in` is high, and `blank_in` must also have been high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | Half-rate phase; low marks wide-format sample edges |
| fmt | input | 2 | Format: 0 8-bit YCbCr, 1 16-bit YCbCr, 2 16-bit RGB, 3 24-bit RGB |
| sync_dir | input | 1 | 1 drives internally timed blank/sync on the drive outputs (static) |
| pix_in | input | 3*CW | Pixel input bus |
| ovl_code_in | input | OCW | Overlay code |
| ovl_mode_in | input | OMW | Overlay mode |
| blank_in | input | 1 | Blank input |
| hsync_in | input | 1 | Horizontal sync input |
| vsync_in | input | 1 | Vertical sync input |
| int_blank | input | 1 | Internally timed blank |
| int_hsync | input | 1 | Internally timed horizontal sync |
| int_vsync | input | 1 | Internally timed vertical sync |
| pix_a | output | CW | Y or R |
| pix_b | output | CW | Cb or G |
| pix_c | output | CW | Cr or B |
| pix_valid | output | 1 | One-cycle strobe per completed pixel |
| ovl_code | output | OCW | Captured overlay code |
| ovl_mode | output | OMW | Captured overlay mode |
| blank_cap | output | 1 | Captured blank |
| hsync_cap | output | 1 | Captured horizontal sync |
| vsync_cap | output | 1 | Captured vertical sync |
| blank_drv | output | 1 | Driven blank |
| hsync_drv | output | 1 | Driven horizontal sync |
| vsync_drv | output | 1 | Driven vertical sync |

## Verification
The 8-bit stream uses distinct byte values in every slot, so a swapped Cb/Cr position or an off-by-one pixel emission shows up as a wrong channel. A mid-group blank shows whether the byte position really restarts at Cb. Toggling `phase` under the 8-bit stream shows that the phase is ignored there.

Each wide format is driven with fresh data on high-phase edges, which separates correct phase qualification from sampling on every edge. The 16-bit YCbCr run checks that chroma alternates starting from Cb. The 5-6-5 patterns use all-ones, all-zeros and single-top-bit fields, which expose errors in field position and in the bit replication.

The overlay captures and the drive outputs are toggled on both phases so that each proves it updates on its own phase only.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    FMT_YC8   = 2'd0,
    FMT_YC16  = 2'd1,
    FMT_RGB16 = 2'd2,
    FMT_RGB24 = 2'd3
  } vic_fmt_e;
endpackage

// File: rtl/vic_byte_demux.sv
// Reassembles the multiplexed Cb,Y,Cr,Y byte stream into full pixels.
module vic_byte_demux #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          blank,
  input  logic [CW-1:0] byte_in,
  output logic          fire,
  output logic [CW-1:0] y_o,
  output logic [CW-1:0] cb_o,
  output logic [CW-1:0] cr_o
);
  localparam int POS_W = 2;

  logic [POS_W-1:0] pos;
  logic [CW-1:0]    cb_r, y0_r, cr_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      cb_r <= '0;
      y0_r <= '0;
      cr_r <= '0;
    end else if (en) begin
      if (blank) begin
        pos <= '0;
      end else begin
        pos <= pos + 1'b1;
        case (pos)
          2'd0:    cb_r <= byte_in;
          2'd1:    y0_r <= byte_in;
          2'd2:    cr_r <= byte_in;
          default: ;
        endcase
      end
    end
  end

  // Even pixel leaves with the Cr byte, odd pixel with its own Y byte.
  always_comb begin
    fire = en && !blank && pos[1];
    cb_o = cb_r;
    y_o  = (pos == 2'd2) ? y0_r : byte_in;
    cr_o = (pos == 2'd2) ? byte_in : cr_r;
  end

  p_pos_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (en && blank) |=> (pos == '0));
endmodule

// File: rtl/vic_wide_unpack.sv
// Unpacks one wide-format sample into three channels.
module vic_wide_unpack
  import vic_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  vic_fmt_e        fmt,
  input  logic            qual,
  input  logic            blank,
  input  logic [3*CW-1:0] din,
  output logic [CW-1:0]   a_o,
  output logic [CW-1:0]   b_o,
  output logic [CW-1:0]   c_o
);
  localparam int R5_W = 5;
  localparam int G6_W = 6;

  logic          sel_cr;
  logic [CW-1:0] cb_r, cr_r;

  function automatic logic [CW-1:0] widen5(input logic [R5_W-1:0] v);
    logic [2*R5_W-1:0] t;
    t = {v, v} >> (2*R5_W - CW);
    return t[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] widen6(input logic [G6_W-1:0] v);
    logic [2*G6_W-1:0] t;
    t = {v, v} >> (2*G6_W - CW);
    return t[CW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_cr <= 1'b0;
      cb_r   <= '0;
      cr_r   <= '0;
    end else if (qual) begin
      if (blank) begin
        sel_cr <= 1'b0;
      end else if (fmt == FMT_YC16) begin
        sel_cr <= !sel_cr;
        if (sel_cr) cr_r <= din[CW-1:0];
        else        cb_r <= din[CW-1:0];
      end
    end
  end

  always_comb begin
    a_o = '0;
    b_o = '0;
    c_o = '0;
    case (fmt)
      FMT_YC16: begin
        a_o = din[2*CW-1:CW];
        b_o = sel_cr ? cb_r : din[CW-1:0];
        c_o = sel_cr ? din[CW-1:0] : cr_r;
      end
      FMT_RGB16: begin
        a_o = widen5(din[15:11]);
        b_o = widen6(din[10:5]);
        c_o = widen5(din[4:0]);
      end
      FMT_RGB24: begin
        a_o = din[3*CW-1:2*CW];
        b_o = din[2*CW-1:CW];
        c_o = din[CW-1:0];
      end
      default: ;
    endcase
  end

  p_chroma_start_r5: assert property (@(posedge clk) disable iff (rst)
    (qual && blank) |=> !sel_cr);
endmodule

// File: rtl/vic_sync_drv.sv
// Registers internally timed blank/sync onto the drive outputs on the high phase.
module vic_sync_drv #(
  parameter int NSIG = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dir,
  input  logic            phase,
  input  logic [NSIG-1:0] lvl_in,
  output logic [NSIG-1:0] lvl_out
);
  always_ff @(posedge clk) begin
    if (rst)        lvl_out <= '0;
    else if (!dir)  lvl_out <= '0;
    else if (phase) lvl_out <= lvl_in;
  end

  p_drive_high_phase_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_out) |-> ($past(phase) || !$past(dir)));
endmodule

// File: rtl/vid_in_capture.sv
module vid_in_capture
  import vic_pkg::*;
#(
  parameter int CW  = 8,
  parameter int OCW = 3,
  parameter int OMW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            phase,
  input  logic [1:0]      fmt,
  input  logic            sync_dir,
  input  logic [3*CW-1:0] pix_in,
  input  logic [OCW-1:0]  ovl_code_in,
  input  logic [OMW-1:0]  ovl_mode_in,
  input  logic            blank_in,
  input  logic            hsync_in,
  input  logic            vsync_in,
  input  logic            int_blank,
  input  logic            int_hsync,
  input  logic            int_vsync,
  output logic [CW-1:0]   pix_a,
  output logic [CW-1:0]   pix_b,
  output logic [CW-1:0]   pix_c,
  output logic            pix_valid,
  output logic [OCW-1:0]  ovl_code,
  output logic [OMW-1:0]  ovl_mode,
  output logic            blank_cap,
  output logic            hsync_cap,
  output logic            vsync_cap,
  output logic            blank_drv,
  output logic            hsync_drv,
  output logic            vsync_drv
);
  localparam int NSYNC = 3;

  vic_fmt_e      fmt_e;
  logic          is8, qual, wide_qual;
  logic          dm_fire;
  logic [CW-1:0] dm_y, dm_cb, dm_cr;
  logic [CW-1:0] wu_a, wu_b, wu_c;
  logic [NSYNC-1:0] drv_lvl;

  assign fmt_e     = vic_fmt_e'(fmt);
  assign is8       = (fmt_e == FMT_YC8);
  assign qual      = is8 || !phase;
  assign wide_qual = !is8 && !phase;

  vic_byte_demux #(.CW(CW)) u_demux (
    .clk(clk), .rst(rst), .en(is8), .blank(blank_in),
    .byte_in(pix_in[CW-1:0]),
    .fire(dm_fire), .y_o(dm_y), .cb_o(dm_cb), .cr_o(dm_cr)
  );

  vic_wide_unpack #(.CW(CW)) u_wide (
    .clk(clk), .rst(rst), .fmt(fmt_e), .qual(wide_qual), .blank(blank_in),
    .din(pix_in), .a_o(wu_a), .b_o(wu_b), .c_o(wu_c)
  );

  vic_sync_drv #(.NSIG(NSYNC)) u_sdrv (
    .clk(clk), .rst(rst), .dir(sync_dir), .phase(phase),
    .lvl_in({int_blank, int_hsync, int_vsync}),
    .lvl_out(drv_lvl)
  );

  assign {blank_drv, hsync_drv, vsync_drv} = drv_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_a     <= '0;
      pix_b     <= '0;
      pix_c     <= '0;
      pix_valid <= 1'b0;
      ovl_code  <= '0;
      ovl_mode  <= '0;
      blank_cap <= 1'b0;
      hsync_cap <= 1'b0;
      vsync_cap <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      if (qual) begin
        ovl_code  <= ovl_code_in;
        ovl_mode  <= ovl_mode_in;
        blank_cap <= blank_in;
        hsync_cap <= hsync_in;
        vsync_cap <= vsync_in;
      end
      if (is8 && dm_fire) begin
        pix_a     <= dm_y;
        pix_b     <= dm_cb;
        pix_c     <= dm_cr;
        pix_valid <= 1'b1;
      end else if (wide_qual && !blank_in) begin
        pix_a     <= wu_a;
        pix_b     <= wu_b;
        pix_c     <= wu_c;
        pix_valid <= 1'b1;
      end
    end
  end

  p_fmt_in_blank_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt) |-> (blank_in && $past(blank_in)));

  p_wide_low_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && ($past(fmt) != FMT_YC8)) |-> (!$past(phase) && !$past(blank_in)));

  p_capture_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (($past(fmt) != FMT_YC8) && $past(phase)) |-> ($stable(ovl_code) && $stable(hsync_cap)));

  p_pair_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (($past(fmt) == FMT_YC8) && pix_valid && $past(pix_valid) && (fmt == FMT_YC8))
      |=> !pix_valid);
endmodule

// File: tb/vid_in_capture_tb.sv
module vid_in_capture_tb;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic sync_dir = 1'b0;
  logic [3*CW-1:0] pix_in = '0;
  logic [2:0] ovl_code_in = '0;
  logic [1:0] ovl_mode_in = '0;
  logic blank_in = 1'b1, hsync_in = 1'b0, vsync_in = 1'b0;
  logic int_blank = 1'b1, int_hsync = 1'b1, int_vsync = 1'b1;
  logic [CW-1:0] pix_a, pix_b, pix_c;
  logic pix_valid;
  logic [2:0] ovl_code;
  logic [1:0] ovl_mode;
  logic blank_cap, hsync_cap, vsync_cap;
  logic blank_drv, hsync_drv, vsync_drv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vid_in_capture #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .phase(phase), .fmt(fmt), .sync_dir(sync_dir),
    .pix_in(pix_in), .ovl_code_in(ovl_code_in), .ovl_mode_in(ovl_mode_in),
    .blank_in(blank_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .int_blank(int_blank), .int_hsync(int_hsync), .int_vsync(int_vsync),
    .pix_a(pix_a), .pix_b(pix_b), .pix_c(pix_c), .pix_valid(pix_valid),
    .ovl_code(ovl_code), .ovl_mode(ovl_mode),
    .blank_cap(blank_cap), .hsync_cap(hsync_cap), .vsync_cap(vsync_cap),
    .blank_drv(blank_drv), .hsync_drv(hsync_drv), .vsync_drv(vsync_drv)
  );

  // {blank, byte, exp_valid, exp_a, exp_b, exp_c}
  localparam logic [33:0] VEC [0:14] = '{
    {1'b1, 8'h00, 1'b0, 24'h000000},
    {1'b0, 8'h10, 1'b0, 24'h000000},
    {1'b0, 8'h20, 1'b0, 24'h000000},
    {1'b0, 8'h30, 1'b1, 24'h201030},
    {1'b0, 8'h21, 1'b1, 24'h211030},
    {1'b0, 8'h40, 1'b0, 24'h000000},
    {1'b0, 8'h50, 1'b0, 24'h000000},
    {1'b0, 8'h60, 1'b1, 24'h504060},
    {1'b0, 8'h51, 1'b1, 24'h514060},
    {1'b0, 8'h70, 1'b0, 24'h000000},
    {1'b1, 8'hFF, 1'b0, 24'h000000},
    {1'b0, 8'h80, 1'b0, 24'h000000},
    {1'b0, 8'h90, 1'b0, 24'h000000},
    {1'b0, 8'hA0, 1'b1, 24'h9080A0},
    {1'b0, 8'h91, 1'b1, 24'h9180A0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic go_fmt(input logic [1:0] f);
    blank_in = 1'b1; phase = 1'b0;
    tick();
    fmt = f; phase = 1'b1;
    tick();
    phase = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pix_in = 24'hFFFFFF;
    ovl_code_in = 3'd7;
    hsync_in = 1'b1;
    repeat (3) tick();
    // R1: reset state
    chk("R1 pix", {7'd0, pix_valid, pix_a, pix_b, pix_c}, 32'h0);
    chk("R1 caps", {ovl_code, ovl_mode, blank_cap, hsync_cap, vsync_cap}, 32'h0);
    chk("R1 drv", {blank_drv, hsync_drv, vsync_drv}, 32'h0);
    rst = 1'b0;
    pix_in = '0; ovl_code_in = '0; hsync_in = 1'b0;

    // R2, R3: 8-bit stream table, phase toggling (ignored in 8-bit)
    for (int i = 0; i < 15; i++) begin
      blank_in = VEC[i][33];
      pix_in = {16'h0, VEC[i][32:25]};
      phase = i[0];
      tick();
      chk($sformatf("R2 R3 valid step %0d", i), {31'd0, pix_valid}, {31'd0, VEC[i][24]});
      if (VEC[i][24])
        chk($sformatf("R2 pixel step %0d", i), {8'd0, pix_a, pix_b, pix_c}, {8'd0, VEC[i][23:0]});
    end

    // R9: sync_dir=0 keeps drive outputs low though int levels are high
    chk("R9 dir0 drv", {blank_drv, hsync_drv, vsync_drv}, 32'h0);

    // R5, R4: 16-bit YCbCr
    go_fmt(2'd1);
    blank_in = 1'b0; phase = 1'b0; pix_in = 24'h001155;
    tick();
    chk("R4 yc16 valid", {31'd0, pix_valid}, 32'd1);
    chk("R5 yc16 first Y Cb", {16'd0, pix_a, pix_b}, 32'h1155);
    phase = 1'b1; pix_in = 24'h00EEEE;
    tick();
    chk("R4 high phase valid", {31'd0, pix_valid}, 32'd0);
    chk("R4 high phase hold", {16'd0, pix_a, pix_b}, 32'h1155);
    phase = 1'b0; pix_in = 24'h002266;
    tick();
    chk("R5 yc16 second", {8'd0, pix_a, pix_b, pix_c}, 32'h225566);
    phase = 1'b1; pix_in = 24'h00EEEE;
    tick();
    phase = 1'b0; pix_in = 24'h003377;
    tick();
    chk("R5 yc16 third", {8'd0, pix_a, pix_b, pix_c}, 32'h337766);

    // R6: 16-bit RGB 5-6-5
    go_fmt(2'd2);
    blank_in = 1'b0; pix_in = 24'h00F81F;
    tick();
    chk("R6 rgb16 F81F", {7'd0, pix_valid, pix_a, pix_b, pix_c}, 32'h01FF00FF);
    phase = 1'b1; pix_in = 24'h0007E0;
    tick();
    chk("R4 rgb16 high phase hold", {8'd0, pix_a, pix_b, pix_c}, 32'hFF00FF);
    phase = 1'b0;
    tick();
    chk("R6 rgb16 07E0", {8'd0, pix_a, pix_b, pix_c}, 32'h00FF00);
    phase = 1'b1;
    tick();
    phase = 1'b0; pix_in = 24'h008410;
    tick();
    chk("R6 rgb16 8410", {8'd0, pix_a, pix_b, pix_c}, 32'h848284);

    // R7, R8: 24-bit RGB with overlay and sync capture
    go_fmt(2'd3);
    blank_in = 1'b0; phase = 1'b0; pix_in = 24'hA1B2C3;
    ovl_code_in = 3'd5; ovl_mode_in = 2'd2; hsync_in = 1'b1; vsync_in = 1'b0;
    tick();
    chk("R7 rgb24", {8'd0, pix_a, pix_b, pix_c}, 32'hA1B2C3);
    chk("R8 capture low phase", {ovl_code, ovl_mode, blank_cap, hsync_cap, vsync_cap}, 32'b10110010);
    phase = 1'b1; pix_in = 24'h123456;
    ovl_code_in = 3'd3; ovl_mode_in = 2'd1; hsync_in = 1'b0; vsync_in = 1'b1;
    tick();
    chk("R8 hold high phase", {ovl_code, ovl_mode, blank_cap, hsync_cap, vsync_cap}, 32'b10110010);
    chk("R7 hold high phase", {8'd0, pix_a, pix_b, pix_c}, 32'hA1B2C3);
    phase = 1'b0;
    tick();
    chk("R8 capture next low", {ovl_code, ovl_mode, blank_cap, hsync_cap, vsync_cap}, 32'b01101001);
    chk("R7 rgb24 second", {8'd0, pix_a, pix_b, pix_c}, 32'h123456);

    // R9: drive outputs on the high phase only
    sync_dir = 1'b1; int_blank = 1'b1; int_hsync = 1'b1; int_vsync = 1'b0;
    phase = 1'b0;
    tick();
    chk("R9 low phase no load", {blank_drv, hsync_drv, vsync_drv}, 32'b000);
    phase = 1'b1;
    tick();
    chk("R9 high phase load", {blank_drv, hsync_drv, vsync_drv}, 32'b110);
    int_hsync = 1'b0; phase = 1'b0;
    tick();
    chk("R9 low phase hold", {blank_drv, hsync_drv, vsync_drv}, 32'b110);
    phase = 1'b1;
    tick();
    chk("R9 high phase update", {blank_drv, hsync_drv, vsync_drv}, 32'b100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule